// File: doc/BRIEF.md
# Latency-Programmed Event Pattern Player

This block replays test events stored in a pattern memory onto a single 32-bit output path when a trigger accept arrives. Each accept carries a 2-bit buffer number that selects one of four equal memory regions. The event at that region's current position is played: its first word is a header that gives the release latency. The words that follow are copied into a small FIFO until a trailer word ends the event. The FIFO is allowed to drain to the output only after a counter has reached the header's latency. Every event therefore reaches the output after a delay that the pattern chooses.

Control flags in the upper four bits of each stored word mark header, trailer and gap words. A gap word makes the output stay idle for one cycle, so the pattern can reproduce holes inside an event. The trailer's payload is made available as an expected-decision value. A length check compares the data words actually played with the count the header declares. The controller handles one event at a time. An accept that arrives while an event is still in progress is dropped and sets a sticky overrun flag. A write port lets a loader fill the memory.

Top module: `evp_player`

## Requirements
- R1: After reset, busy, out_valid, overrun and len_err are low, and trl_info is zero.
- R2: A memory word's bits 31:0 are the payload and appear unchanged on out_data. Bit 35 flags a header, bit 34 a trailer and bit 33 a gap. Bit 32 is reserved and has no effect: a word with only bit 32 set plays as ordinary data.
- R3: The memory read address is the accepted buffer number (most significant two bits) joined to that region's read pointer. After reset every region's pointer is at offset 0.
- R4: Header bits 15:0 give the latency L in cycles. The first output word is valid in the cycle after the (max(L,1)+2)-th rising edge that follows the edge sampling the accept.
- R5: out_valid is never high before the latency counter of the current event has reached L.
- R6: Data words come out in stored order, each exactly once, with no idle cycles between them except those caused by gap words.
- R7: Each gap word yields exactly one cycle with out_valid low, placed at its position in the event.
- R8: The trailer is not output. Its bits 31:0 appear on trl_info and are held until the next trailer. At the trailer, len_err is set when the number of non-gap data words differs from header bits 23:16, or when the first word lacks the header flag; otherwise len_err is cleared.
- R9: Each region's pointer advances past the trailer, so consecutive accepts on one buffer play consecutive events, and playing one region leaves the others' positions unchanged.
- R10: When the FIFO is full, reading from memory stalls; an event longer than the FIFO delivers every word.
- R11: busy is high from the edge after an accept until the edge after the last word leaves. An accept seen while busy is ignored, does not move any pointer, and sets overrun, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pm_wr_en | input | 1 | Pattern memory write strobe |
| pm_wr_addr | input | AW | Pattern memory write address |
| pm_wr_data | input | 36 | Pattern memory write word |
| trig_acc | input | 1 | Trigger accept strobe |
| trig_buf | input | 2 | Buffer number sampled with the accept |
| busy | output | 1 | An event is being read or played |
| out_valid | output | 1 | out_data carries a data word this cycle |
| out_data | output | 32 | Four 8-bit output lanes |
| trl_info | output | 32 | Payload of the last trailer read |
| len_err | output | 1 | Length or header-format mismatch of the last event |
| overrun | output | 1 | Sticky: an accept arrived while busy |

## Verification
On every cycle, the assertions check four things. Output never appears before the latency counter has released. The counter never passes its target, and it releases right after the header only for a zero latency. The FIFO is never pushed when full or popped when empty. An accept while busy always sets the sticky overrun flag, and output only appears while busy. Only the bench scenarios can show the exact cycle of the first output word, the order and completeness of the payload, and the placement of gap idles. They also show trailer and length-check results, the per-region pointer stepping from event to event, and that a dropped accept leaves the next event on its buffer unchanged.

// File: rtl/evp_pkg.sv
package evp_pkg;

  localparam int WORD_W = 36;
  localparam int LANE_W = 32;
  localparam int LAT_W  = 16;
  localparam int CNT_W  = 8;
  localparam int NBUF   = 4;

  typedef logic [WORD_W-1:0] pword_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HEAD  = 2'd1,
    ST_FILL  = 2'd2,
    ST_DRAIN = 2'd3
  } evp_state_t;

  function automatic logic [LAT_W-1:0] hdr_latency(input pword_t w);
    return w[LAT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] hdr_count(input pword_t w);
    return w[LAT_W+CNT_W-1:LAT_W];
  endfunction

  function automatic logic flag_header(input pword_t w);
    return w[35];
  endfunction

  function automatic logic flag_trailer(input pword_t w);
    return w[34];
  endfunction

  function automatic logic flag_gap(input pword_t w);
    return w[33];
  endfunction

  function automatic logic [LANE_W-1:0] payload(input pword_t w);
    return w[LANE_W-1:0];
  endfunction

endpackage

// File: rtl/evp_pmem.sv
module evp_pmem #(
  parameter int AW = 8
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  evp_pkg::pword_t       wr_data,
  input  logic [AW-1:0]         rd_addr,
  output evp_pkg::pword_t       rd_data
);
  localparam int DEPTH = 1 << AW;

  evp_pkg::pword_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/evp_fifo.sv
module evp_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (fill_q == '0);
  assign full  = (fill_q == CW'(DEPTH));
  assign dout  = store_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      case ({push, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

endmodule

// File: rtl/evp_release.sv
module evp_release #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] lat_in,
  output logic          released
);
  logic [LW-1:0] cnt_q, lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      lat_q <= lat_in;
    end else if (cnt_q != lat_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign released = (cnt_q == lat_q);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lat_q);

  // R4
  zero_lat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (released == ($past(lat_in) == '0)));

endmodule

// File: rtl/evp_player.sv
module evp_player #(
  parameter int AW         = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_wr_en,
  input  logic [AW-1:0] pm_wr_addr,
  input  logic [35:0]   pm_wr_data,
  input  logic          trig_acc,
  input  logic [1:0]    trig_buf,
  output logic          busy,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic [31:0]   trl_info,
  output logic          len_err,
  output logic          overrun
);
  import evp_pkg::*;

  localparam int RW   = AW - 2;
  localparam int FW   = LANE_W + 1;
  localparam int GAPB = LANE_W;

  evp_state_t      st_q;
  logic [1:0]      buf_q;
  logic [RW-1:0]   ptr_q [NBUF];
  logic [AW-1:0]   rd_addr;
  pword_t          rd_word;
  logic [CNT_W-1:0] dcount_q, want_q;
  logic            hdr_bad_q;

  // named internal events
  logic acc_take, acc_drop, hdr_take, fetch, word_trl, ff_push, ff_pop;
  logic ev_done, rd_adv, released, ff_empty, ff_full;
  logic [FW-1:0] ff_din, ff_dout;

  assign rd_addr  = {buf_q, ptr_q[buf_q]};
  assign acc_take = trig_acc && (st_q == ST_IDLE);
  assign acc_drop = trig_acc && (st_q != ST_IDLE);
  assign hdr_take = (st_q == ST_HEAD);
  assign fetch    = (st_q == ST_FILL) && !ff_full;
  assign word_trl = fetch && flag_trailer(rd_word);
  assign ff_push  = fetch && !flag_trailer(rd_word);
  assign ff_din   = {flag_gap(rd_word), payload(rd_word)};
  assign ff_pop   = ((st_q == ST_FILL) || (st_q == ST_DRAIN)) && released && !ff_empty;
  assign ev_done  = (st_q == ST_DRAIN) && released && ff_empty;
  assign rd_adv   = hdr_take || fetch;
  assign busy     = (st_q != ST_IDLE);

  evp_pmem #(.AW(AW)) u_pmem (
    .clk     (clk),
    .wr_en   (pm_wr_en),
    .wr_addr (pm_wr_addr),
    .wr_data (pm_wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  evp_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ff_push),
    .din   (ff_din),
    .pop   (ff_pop),
    .dout  (ff_dout),
    .empty (ff_empty),
    .full  (ff_full)
  );

  evp_release #(.LW(LAT_W)) u_rel (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hdr_take),
    .lat_in   (hdr_latency(rd_word)),
    .released (released)
  );

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      buf_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (acc_take) begin
                    st_q  <= ST_HEAD;
                    buf_q <= trig_buf;
                  end
        ST_HEAD:  st_q <= ST_FILL;
        ST_FILL:  if (word_trl) st_q <= ST_DRAIN;
        ST_DRAIN: if (ev_done) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // per-region read pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) ptr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++)
        if (rd_adv && (buf_q == 2'(i))) ptr_q[i] <= ptr_q[i] + 1'b1;
    end
  end

  // event bookkeeping: length check and trailer capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcount_q  <= '0;
      want_q    <= '0;
      hdr_bad_q <= 1'b0;
      trl_info  <= '0;
      len_err   <= 1'b0;
    end else begin
      if (hdr_take) begin
        dcount_q  <= '0;
        want_q    <= hdr_count(rd_word);
        hdr_bad_q <= !flag_header(rd_word);
      end else if (ff_push && !flag_gap(rd_word)) begin
        dcount_q <= dcount_q + 1'b1;
      end
      if (word_trl) begin
        trl_info <= payload(rd_word);
        len_err  <= (dcount_q != want_q) || hdr_bad_q;
      end
    end
  end

  // output stage and overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= ff_pop && !ff_dout[GAPB];
      out_data  <= (ff_pop && !ff_dout[GAPB]) ? ff_dout[LANE_W-1:0] : '0;
      if (acc_drop) overrun <= 1'b1;
    end
  end

  // R5
  release_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(released));

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop |=> overrun);

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R11
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FILL) && ff_full) |=> $stable(ptr_q[buf_q]));

endmodule

// File: tb/evp_player_tb.sv
`timescale 1ns/1ps
module evp_player_tb;

  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_wr_en = 1'b0;
  logic [AW-1:0] pm_wr_addr = '0;
  logic [35:0] pm_wr_data = '0;
  logic        trig_acc = 1'b0;
  logic [1:0]  trig_buf = '0;
  logic        busy, out_valid, len_err, overrun;
  logic [31:0] out_data, trl_info;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          exp_n;
  logic [31:0] exp_w [16];

  always #2 clk = ~clk;

  evp_player #(.AW(AW), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pm_wr_en(pm_wr_en), .pm_wr_addr(pm_wr_addr), .pm_wr_data(pm_wr_data),
    .trig_acc(trig_acc), .trig_buf(trig_buf),
    .busy(busy), .out_valid(out_valid), .out_data(out_data),
    .trl_info(trl_info), .len_err(len_err), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // word builders: flags {hdr,trl,gap,rsv} over 32-bit payload
  function automatic logic [35:0] w_hdr(input int lat, input int cnt);
    return {4'b1000, 8'h00, 8'(cnt), 16'(lat)};
  endfunction
  function automatic logic [35:0] w_dat(input logic [31:0] d);
    return {4'b0000, d};
  endfunction
  function automatic logic [35:0] w_rsv(input logic [31:0] d);
    return {4'b0001, d};
  endfunction
  function automatic logic [35:0] w_gap();
    return {4'b0010, 32'h0};
  endfunction
  function automatic logic [35:0] w_trl(input logic [31:0] d);
    return {4'b0100, d};
  endfunction

  task automatic wr(input int addr, input logic [35:0] d);
    @(negedge clk);
    pm_wr_en = 1'b1; pm_wr_addr = AW'(addr); pm_wr_data = d;
    @(negedge clk);
    pm_wr_en = 1'b0;
  endtask

  // play one event; expected payload in exp_w/exp_n
  task automatic play(input logic [1:0] b, input int lat, input int gaps,
                      input logic [31:0] trl, input bit lerr, input string req,
                      input int intr_k, input logic [1:0] intr_b);
    int first = -1;
    int n = 0;
    int idle = 0;
    int want_first;
    logic [31:0] got [16];
    want_first = ((lat < 1) ? 1 : lat) + 2;
    @(negedge clk);
    trig_acc = 1'b1; trig_buf = b;
    @(negedge clk);
    for (int k = 1; k < 300; k++) begin
      if (k == intr_k) begin trig_acc = 1'b1; trig_buf = intr_b; end
      else trig_acc = 1'b0;
      @(negedge clk);
      if (out_valid) begin
        if (first < 0) first = k;
        if (n < 16) got[n] = out_data;
        n++;
      end else if (first >= 0 && busy) begin
        idle++;
      end
      if (!busy && !out_valid) break;
    end
    trig_acc = 1'b0;
    chk(first == want_first, req, "first valid edge", first, want_first);
    chk(n == exp_n, req, "word count", n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++)
      chk(got[i] == exp_w[i], req, "payload word", got[i], exp_w[i]);
    chk(idle == gaps, req, "gap idle cycles (R7)", idle, gaps);
    chk(trl_info == trl, req, "trailer info (R8)", trl_info, trl);
    chk(len_err == lerr, req, "length check (R8)", len_err, lerr);
    chk(busy == 1'b0, req, "busy after event (R11)", busy, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(overrun == 0, "R1", "overrun", overrun, 0);
    chk(len_err == 0, "R1", "len_err", len_err, 0);
    chk(trl_info == 0, "R1", "trl_info", trl_info, 0);
  endtask

  // R2 R4 R6 R7: gap and reserved-bit word in buffer 0, latency 5
  task automatic t_gap_event();
    exp_n = 3;
    exp_w[0] = 32'h1111_0001; exp_w[1] = 32'h2222_0002; exp_w[2] = 32'h3333_0003;
    play(2'd0, 5, 1, 32'hCAFE_0001, 1'b0, "R2/R4/R6/R7", 0, 2'd0);
  endtask

  // R10: six words through a four-entry FIFO, long latency, bad count R8
  task automatic t_fifo_stall();
    exp_n = 6;
    for (int i = 0; i < 6; i++) exp_w[i] = 32'hF000_0000 + 32'(i);
    play(2'd1, 20, 0, 32'hBEEF_0002, 1'b1, "R10", 0, 2'd0);
  endtask

  // R9 R3: second accept on buffer 0 plays the next event, zero latency
  task automatic t_region_next();
    exp_n = 2;
    exp_w[0] = 32'hE000_0000; exp_w[1] = 32'hE000_0001;
    play(2'd0, 0, 0, 32'hCAFE_0002, 1'b0, "R9", 0, 2'd0);
  endtask

  // R4: latency one in buffer 2
  task automatic t_short();
    exp_n = 1;
    exp_w[0] = 32'h6000_0000;
    play(2'd2, 1, 0, 32'h0000_0003, 1'b0, "R4", 0, 2'd0);
  endtask

  // R11: accept on buffer 0 while busy is dropped and flagged
  task automatic t_overrun();
    chk(overrun == 0, "R11", "overrun before", overrun, 0);
    exp_n = 1;
    exp_w[0] = 32'h7000_0000;
    play(2'd2, 30, 0, 32'h0000_0004, 1'b0, "R11", 5, 2'd0);
    chk(overrun == 1, "R11", "overrun after drop", overrun, 1);
    exp_n = 1;
    exp_w[0] = 32'h8000_0000;
    play(2'd0, 2, 0, 32'hCAFE_0003, 1'b0, "R11", 0, 2'd0);
    chk(overrun == 1, "R11", "overrun sticky", overrun, 1);
  endtask

  task automatic load_patterns();
    // buffer 0: event A (0..5), B (6..9), C (10..12)
    wr(0, w_hdr(5, 3));
    wr(1, w_dat(32'h1111_0001));
    wr(2, w_rsv(32'h2222_0002));
    wr(3, w_gap());
    wr(4, w_dat(32'h3333_0003));
    wr(5, w_trl(32'hCAFE_0001));
    wr(6, w_hdr(0, 2));
    wr(7, w_dat(32'hE000_0000));
    wr(8, w_dat(32'hE000_0001));
    wr(9, w_trl(32'hCAFE_0002));
    wr(10, w_hdr(2, 1));
    wr(11, w_dat(32'h8000_0000));
    wr(12, w_trl(32'hCAFE_0003));
    // buffer 1: six data words, header claims seven
    wr(64, w_hdr(20, 7));
    for (int i = 0; i < 6; i++) wr(65 + i, w_dat(32'hF000_0000 + 32'(i)));
    wr(71, w_trl(32'hBEEF_0002));
    // buffer 2: two events
    wr(128, w_hdr(1, 1));
    wr(129, w_dat(32'h6000_0000));
    wr(130, w_trl(32'h0000_0003));
    wr(131, w_hdr(30, 1));
    wr(132, w_dat(32'h7000_0000));
    wr(133, w_trl(32'h0000_0004));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_patterns();
    t_gap_event();
    t_fifo_stall();
    t_region_next();
    t_short();
    t_overrun();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule